// File: doc/BRIEF.md
# Memory Error Interrupt Unit

This unit sits beside a memory controller and turns its error strobes into software-visible state. Each error strobe sets a sticky bit in a cause register. The cause bits fall into four classes: correctable ECC, uncorrectable ECC, a per-lane parity field, and address faults. An enable register gates the cause bits into two outputs. The first is a summary interrupt that goes to the chip-level interrupt aggregator. The second is a fatal flag, which only the uncorrectable, parity and address classes can raise.

The two ECC classes each have their own capture bank. A bank holds the failing memory address and the data words that came with the event. Software reads the banks through a small register port. After handling an error, software clears the cause bits by writing ones to them. A bank keeps the first error of its class until software clears that class's cause bit, so later events of the same class cannot overwrite the evidence.

Top module: `mem_err_irq`

## Requirements
- R1: After reset, every register reads zero, and `irq` and `fatal` are low.
- R2: An event strobe sampled at a clock edge sets its cause bit, which is readable at word 0 after that edge. The cause bit layout is:
  - bit 0: correctable ECC (`ce_hit`)
  - bit 1: uncorrectable ECC (`ue_hit`)
  - bits 2..5: parity, one bit per lane (`par_hit[k]` sets bit 2+k)
  - bit 6: address fault (`addr_fault`)
  - bits above 6: read as zero.
- R3: A write to word 0 clears exactly the cause bits whose write-data bit is one. All other cause bits keep their value.
- R4: If an event arrives in the same cycle as a write-one-to-clear of its bit, the bit stays set.
- R5: `irq` is high exactly when some cause bit is set and its enable bit at word 1 is also set. An enable value of zero masks every cause.
- R6: `fatal` is high exactly when cause bit 1, 2, 3, 4, 5 or 6 is set together with its enable bit. Cause bit 0 never raises `fatal`.
- R7: A correctable event records `ce_addr` at word 2. It also records the five 32-bit words of `ce_data` at words 3..7, with word k at `ce_data[32k +: 32]`.
- R8: An uncorrectable event records `ue_addr` at word 8 and the words of `ue_data` at words 9..13, in the same word order as R7.
- R9: A capture bank is loaded only when its class's cause bit is clear, or when that bit is being cleared in the same cycle. Otherwise the bank keeps its first recorded error.
- R10: The enable register stores only the low 7 bits that are written. Reads from words 14 and 15 return zero, and writes to those words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data (combinational) |
| ce_hit | input | 1 | Correctable ECC event strobe |
| ce_addr | input | 32 | Failing address of the correctable event |
| ce_data | input | 160 | Data words of the correctable event |
| ue_hit | input | 1 | Uncorrectable ECC event strobe |
| ue_addr | input | 32 | Failing address of the uncorrectable event |
| ue_data | input | 160 | Data words of the uncorrectable event |
| par_hit | input | 4 | Parity error strobe, one per lane |
| addr_fault | input | 1 | Address error strobe |
| irq | output | 1 | Summary interrupt |
| fatal | output | 1 | Fatal error flag |

## Verification
The bench drives every one of the 128 possible event patterns into a cleared cause register. For each pattern it reads back the cause word, then sweeps all 128 enable values, and computes the expected `irq` and `fatal` as masked ORs. This sweep separates a wrong bit position, a missing lane, or a wrong fatal subset from a correct gate.

Directed sequences cover the capture banks:
- a first event, then a second event of the same class, to show the bank holds its first error;
- a clear followed by a fresh event;
- an event in the same cycle as its clear;
- an event in the other class, to show the banks are independent.

Partial clears, enable truncation and the unmapped words complete the set.

// File: rtl/mei_pkg.sv
package mei_pkg;
  // Fixed cause bit positions; software decodes these.
  localparam int CE_BIT  = 0;
  localparam int UE_BIT  = 1;
  localparam int PAR_LSB = 2;

  // Register word indices that do not depend on the capture word count.
  localparam int REG_CAUSE   = 0;
  localparam int REG_ENABLE  = 1;
  localparam int REG_CE_ADDR = 2;

  function automatic int cause_width(input int lanes);
    return lanes + 3;
  endfunction

  function automatic int addr_bit(input int lanes);
    return lanes + 2;
  endfunction

  // Every class except the correctable one is fatal.
  function automatic logic [31:0] fatal_mask(input int lanes);
    logic [31:0] m;
    m = '0;
    for (int i = 1; i < lanes + 3; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/mei_cause.sv
module mei_cause #(
  parameter int CW = 7,
  parameter logic [31:0] FMASK = 32'h7e
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cause_i,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [CW-1:0] ev_i,
  output logic [CW-1:0] cause_o,
  output logic [CW-1:0] en_o,
  output logic [CW-1:0] clr_o,
  output logic          irq_o,
  output logic          fatal_o
);
  logic [CW-1:0] cause_q, en_q, gated;

  assign clr_o = wr_cause_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      en_q    <= '0;
    end else begin
      cause_q <= (cause_q & ~clr_o) | ev_i;
      if (wr_en_i) en_q <= wdata_i;
    end
  end

  assign gated   = cause_q & en_q;
  assign irq_o   = |gated;
  assign fatal_o = |(gated & FMASK[CW-1:0]);
  assign cause_o = cause_q;
  assign en_o    = en_q;

  // R2
  ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((cause_q & $past(ev_i)) == $past(ev_i)));
  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cause_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  // R6
  fatal_in_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |-> irq_o);
  // R6
  ce_not_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & FMASK[CW-1:0]) == '0) |-> !fatal_o);
endmodule

// File: rtl/mei_capture.sv
module mei_capture #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_i,
  input  logic            pend_i,
  input  logic            clr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NW*DW-1:0] data_i,
  output logic [AW-1:0]   addr_o,
  output logic [NW*DW-1:0] data_o
);
  logic take;
  assign take = evt_i & (~pend_i | clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_o <= '0;
    else if (take) addr_o <= addr_i;
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)    data_o[w*DW +: DW] <= '0;
      else if (take) data_o[w*DW +: DW] <= data_i[w*DW +: DW];
    end
  end

  // R9
  hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i && !clr_i) |=> ($stable(addr_o) && $stable(data_o)));
  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !pend_i) |=> (addr_o == $past(addr_i)));
endmodule

// File: rtl/mem_err_irq.sv
module mem_err_irq #(
  parameter int ADDR_W    = 4,
  parameter int DW        = 32,
  parameter int MEM_AW    = 32,
  parameter int NWORDS    = 5,
  parameter int PAR_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  input  logic                 reg_we,
  output logic [DW-1:0]        reg_rdata,
  input  logic                 ce_hit,
  input  logic [MEM_AW-1:0]    ce_addr,
  input  logic [NWORDS*DW-1:0] ce_data,
  input  logic                 ue_hit,
  input  logic [MEM_AW-1:0]    ue_addr,
  input  logic [NWORDS*DW-1:0] ue_data,
  input  logic [PAR_LANES-1:0] par_hit,
  input  logic                 addr_fault,
  output logic                 irq,
  output logic                 fatal
);
  import mei_pkg::*;

  localparam int CW         = cause_width(PAR_LANES);
  localparam int ABIT       = addr_bit(PAR_LANES);
  localparam int CE_DATA0   = REG_CE_ADDR + 1;
  localparam int UE_ADDR_IX = CE_DATA0 + NWORDS;
  localparam int UE_DATA0   = UE_ADDR_IX + 1;

  logic [CW-1:0] ev_vec, cause_q, en_q, clr_vec;
  logic          wr_cause, wr_en;
  logic [MEM_AW-1:0]    ce_addr_q, ue_addr_q;
  logic [NWORDS*DW-1:0] ce_data_q, ue_data_q;

  always_comb begin
    ev_vec                        = '0;
    ev_vec[CE_BIT]                = ce_hit;
    ev_vec[UE_BIT]                = ue_hit;
    ev_vec[PAR_LSB +: PAR_LANES]  = par_hit;
    ev_vec[ABIT]                  = addr_fault;
  end

  assign wr_cause = reg_we && (int'(reg_addr) == REG_CAUSE);
  assign wr_en    = reg_we && (int'(reg_addr) == REG_ENABLE);

  mei_cause #(.CW(CW), .FMASK(fatal_mask(PAR_LANES))) u_cause (
    .clk(clk), .rst_n(rst_n), .wr_cause_i(wr_cause), .wr_en_i(wr_en),
    .wdata_i(reg_wdata[CW-1:0]), .ev_i(ev_vec), .cause_o(cause_q),
    .en_o(en_q), .clr_o(clr_vec), .irq_o(irq), .fatal_o(fatal)
  );

  mei_capture #(.AW(MEM_AW), .DW(DW), .NW(NWORDS)) u_ce_cap (
    .clk(clk), .rst_n(rst_n), .evt_i(ce_hit), .pend_i(cause_q[CE_BIT]),
    .clr_i(clr_vec[CE_BIT]), .addr_i(ce_addr), .data_i(ce_data),
    .addr_o(ce_addr_q), .data_o(ce_data_q)
  );

  mei_capture #(.AW(MEM_AW), .DW(DW), .NW(NWORDS)) u_ue_cap (
    .clk(clk), .rst_n(rst_n), .evt_i(ue_hit), .pend_i(cause_q[UE_BIT]),
    .clr_i(clr_vec[UE_BIT]), .addr_i(ue_addr), .data_i(ue_data),
    .addr_o(ue_addr_q), .data_o(ue_data_q)
  );

  always_comb begin
    int ix;
    ix        = int'(reg_addr);
    reg_rdata = '0;
    if (ix == REG_CAUSE)   reg_rdata = DW'(cause_q);
    if (ix == REG_ENABLE)  reg_rdata = DW'(en_q);
    if (ix == REG_CE_ADDR) reg_rdata = DW'(ce_addr_q);
    if (ix == UE_ADDR_IX)  reg_rdata = DW'(ue_addr_q);
    for (int w = 0; w < NWORDS; w++) begin
      if (ix == CE_DATA0 + w) reg_rdata = ce_data_q[w*DW +: DW];
      if (ix == UE_DATA0 + w) reg_rdata = ue_data_q[w*DW +: DW];
    end
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_hit && wr_cause && reg_wdata[CE_BIT]) |=> cause_q[CE_BIT]);
  // R5
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: tb/tb_mem_err_irq.sv
module tb_mem_err_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        ce_hit = 1'b0, ue_hit = 1'b0, addr_fault = 1'b0;
  logic [31:0] ce_addr = '0, ue_addr = '0;
  logic [159:0] ce_data = '0, ue_data = '0;
  logic [3:0]  par_hit = '0;
  logic        irq, fatal;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  mem_err_irq dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .ce_hit(ce_hit), .ce_addr(ce_addr),
    .ce_data(ce_data), .ue_hit(ue_hit), .ue_addr(ue_addr), .ue_data(ue_data),
    .par_hit(par_hit), .addr_fault(addr_fault), .irq(irq), .fatal(fatal)
  );

  function automatic logic [31:0] word_of(input logic [31:0] a, input int k);
    return (a * 32'd3) ^ (32'h0101_0101 * (k + 1));
  endfunction

  function automatic logic [159:0] pack(input logic [31:0] a);
    logic [159:0] v;
    for (int k = 0; k < 5; k++) v[32*k +: 32] = word_of(a, k);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = 4'(a);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  // Drive one event pattern for one cycle; optionally with a cause write.
  task automatic pulse(input logic [6:0] p, input logic [31:0] ca, input logic [31:0] ua,
                       input bit do_clr, input logic [31:0] clr);
    @(negedge clk);
    ce_hit = p[0]; ue_hit = p[1]; par_hit = p[5:2]; addr_fault = p[6];
    ce_addr = ca; ce_data = pack(ca); ue_addr = ua; ue_data = pack(ua);
    if (do_clr) begin reg_addr = 4'd0; reg_wdata = clr; reg_we = 1'b1; end
    @(negedge clk);
    ce_hit = 1'b0; ue_hit = 1'b0; par_hit = '0; addr_fault = 1'b0; reg_we = 1'b0;
  endtask

  task automatic bank_chk(input int base, input logic [31:0] a, input string tag);
    rd_chk(base, a, tag);
    for (int k = 0; k < 5; k++) rd_chk(base + 1 + k, word_of(a, k), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 16; a++) rd_chk(a, 32'h0, "R1 reset read");
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fatal", {31'b0, fatal}, 0);

    // R2 R5 R6: all event patterns times all enable values
    for (int p = 0; p < 128; p++) begin
      wr(0, 32'hFFFF_FFFF);
      pulse(7'(p), 32'h0, 32'h0, 1'b0, 0);
      rd_chk(0, 32'(p), "R2 cause layout");
      for (int e = 0; e < 128; e++) begin
        wr(1, 32'(e));
        chk("R5 irq", {31'b0, irq}, {31'b0, ((p & e) != 0)});
        chk("R6 fatal", {31'b0, fatal}, {31'b0, ((p & e & 32'h7e) != 0)});
      end
    end

    // R3: partial clear, zero write
    wr(0, 32'hFFFF_FFFF);
    pulse(7'h7f, 32'h0, 32'h0, 1'b0, 0);
    wr(0, 32'h55);
    rd_chk(0, 32'h2a, "R3 partial clear");
    wr(0, 32'h0);
    rd_chk(0, 32'h2a, "R3 zero write");

    // R10: enable width, unmapped words
    wr(1, 32'hFFFF_FFFF);
    rd_chk(1, 32'h7f, "R10 enable width");
    wr(15, 32'hFFFF_FFFF);
    wr(14, 32'hFFFF_FFFF);
    rd_chk(15, 32'h0, "R10 unmapped read");
    rd_chk(14, 32'h0, "R10 unmapped read");
    rd_chk(0, 32'h2a, "R10 unmapped write cause");
    rd_chk(1, 32'h7f, "R10 unmapped write enable");

    // R7 R9: correctable capture
    wr(0, 32'hFFFF_FFFF);
    pulse(7'h01, 32'hA000_0010, 32'h0, 1'b0, 0);
    bank_chk(2, 32'hA000_0010, "R7 ce capture");
    pulse(7'h01, 32'hA000_0020, 32'h0, 1'b0, 0);
    bank_chk(2, 32'hA000_0010, "R9 ce holds first");
    wr(0, 32'h1);
    pulse(7'h01, 32'hA000_0030, 32'h0, 1'b0, 0);
    bank_chk(2, 32'hA000_0030, "R9 ce recapture");
    // R4 and R9: event in the same cycle as its clear
    pulse(7'h01, 32'hA000_0040, 32'h0, 1'b1, 32'h1);
    rd_chk(0, 32'h1, "R4 set beats clear");
    bank_chk(2, 32'hA000_0040, "R9 ce capture on clear");

    // R8 R9: uncorrectable capture, banks independent
    pulse(7'h02, 32'h0, 32'hB000_0100, 1'b0, 0);
    bank_chk(8, 32'hB000_0100, "R8 ue capture");
    bank_chk(2, 32'hA000_0040, "R8 ce bank untouched");
    pulse(7'h02, 32'h0, 32'hB000_0200, 1'b0, 0);
    bank_chk(8, 32'hB000_0100, "R9 ue holds first");
    pulse(7'h02, 32'h0, 32'hB000_0300, 1'b1, 32'h2);
    rd_chk(0, 32'h3, "R4 ue set beats clear");
    bank_chk(8, 32'hB000_0300, "R9 ue capture on clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule